// File: doc/BRIEF.md
# Converter Offset Calibration Sequencer

This block runs offset calibration for a set of converter channels (two by default). Software starts a channel's calibration by writing a 1 into that channel's bit of a small control register. While the run lasts, the block holds that channel's analog input in high impedance, keeps its output path in reset and marks its serial output data as not valid. It sums the ADC samples taken at each sample-rate strobe over a fixed window of 1024 strobes. At the end it latches the average as the channel's offset estimate and clears the control bit by itself.

After calibration, the stored offset is subtracted from every later ADC sample on the corrected-sample output. A synchronous power-down request or the asynchronous reset discards every stored offset and stops any run in progress. Neither one starts a new run: software must request calibration again.

Top module: `offset_cal_seq`

## Requirements
- R1: Writing with `ctl_wr` high and bit i of `ctl_wdata` at 1 starts calibration of channel i (bit 0 is channel 0, bit 1 is channel 1). From the next clock, `ctl_rdata` bit i reads 1 for as long as the run lasts.
- R2: A run lasts exactly 1024 sample strobes. Strobes in the cycle of the start write do not count. Clock cycles without `smp_stb` do not advance the run.
- R3: In the clock after the 1024th counted strobe, `ctl_rdata` bit i returns to 0 without any software write.
- R4: While channel i calibrates, `in_hiz[i]` and `out_rst[i]` are 1 and `data_vld[i]` is 0. When the channel is idle, the first two are 0 and `data_vld[i]` is 1.
- R5: At the end of a run, `ofs_val` lane i (bits 16*i+15 : 16*i, two's complement) takes the floor of the sum of the 1024 counted samples divided by 1024, which is an arithmetic right shift by 10. The lane holds that value unchanged until the next run ends or a clear.
- R6: `cor_smp` lane i equals `adc_smp` lane i minus `ofs_val` lane i, saturated to the signed 16-bit range [-32768, 32767].
- R7: Writing 1 to a channel's bit during its run does not restart or extend the run. Writing 0 to a bit has no effect, whether the channel is idle or running.
- R8: Channels calibrate independently and may run at the same time. Each channel has its own count, so each ends 1024 strobes after its own start.
- R9: Reset or a one-cycle `pwr_dn` pulse stops all runs and sets every `ofs_val` lane to 0. No calibration starts afterwards until software writes a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Synchronous power-down: clears runs and stored offsets |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | NUM_CH | Start bits, one per channel |
| ctl_rdata | output | NUM_CH | Busy bits, one per channel (self-clearing) |
| smp_stb | input | 1 | Sample-rate strobe, one clock per sample period |
| adc_smp | input | NUM_CH*SAMPLE_W | Packed signed ADC samples, channel 0 in low lane |
| in_hiz | output | NUM_CH | Analog input high-impedance request per channel |
| out_rst | output | NUM_CH | Output path reset per channel |
| data_vld | output | NUM_CH | Serial output data valid per channel |
| ofs_val | output | NUM_CH*SAMPLE_W | Packed stored offset estimates |
| cor_smp | output | NUM_CH*SAMPLE_W | Packed offset-corrected samples |

## Verification
The assertions check on every cycle that the run count moves only on a strobe and that a busy bit falls only after the last strobe or a power-down. They also check that the analog controls follow the busy bit, that the offset register changes only at the end of a run or on a clear, and that power-down empties it. Only the bench's scenarios can show the values that need a whole run: the exact 1024-strobe length, the floor rounding of a negative average, independent end times for staggered channels, the start write ignored during a run, saturation at both ends of the corrected range, and that no run follows power-down.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CAL  = 1'b1
   } cal_st_e;
endpackage

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
   import ocal_pkg::*;
#(
   parameter int CAL_LOG2 = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_dn,
   input  logic start_req,
   input  logic smp_stb,
   output logic busy,
   output logic clr_acc,
   output logic last_smp
);
   localparam int CNT_W = CAL_LOG2;
   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

   cal_st_e          st_q;
   logic [CNT_W-1:0] cnt_q;

   assign busy     = (st_q == ST_CAL);
   assign clr_acc  = start_req && !busy && !pwr_dn;
   assign last_smp = busy && smp_stb && (cnt_q == CNT_LAST) && !pwr_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (pwr_dn) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (clr_acc) begin
         st_q  <= ST_CAL;
         cnt_q <= '0;
      end else if (busy && smp_stb) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_LAST) st_q <= ST_IDLE;
      end
   end

   // R2: no progress without a strobe, and a repeated start write does not restart the run (R7)
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !smp_stb && !pwr_dn |=> busy && $stable(cnt_q));

   // R3: the run ends only after the last strobe or on power-down
   assert_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(pwr_dn) || ($past(smp_stb) && ($past(cnt_q) == CNT_LAST)));

   // R7: a start request during a run leaves the count running forward
   assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start_req && smp_stb && !pwr_dn && (cnt_q != CNT_LAST) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/ocal_accum.sv
module ocal_accum #(
   parameter int SAMPLE_W = 16,
   parameter int CAL_LOG2 = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pwr_dn,
   input  logic                       clr_acc,
   input  logic                       acc_en,
   input  logic                       last_smp,
   input  logic signed [SAMPLE_W-1:0] smp,
   output logic signed [SAMPLE_W-1:0] ofs
);
   localparam int ACC_W = SAMPLE_W + CAL_LOG2;

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] sum_nx;

   assign sum_nx = acc_q + ACC_W'(smp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ofs   <= '0;
      end else if (pwr_dn) begin
         acc_q <= '0;
         ofs   <= '0;
      end else if (clr_acc) begin
         acc_q <= '0;
      end else if (acc_en) begin
         acc_q <= sum_nx;
         if (last_smp) ofs <= sum_nx[ACC_W-1:CAL_LOG2];
      end
   end

   // R5: the stored offset moves only at the end of a run or on a clear
   assert_ofs_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ofs) |-> $past(last_smp) || $past(pwr_dn));

   // R9: power-down empties the stored offset
   assert_pd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> ofs == '0);
endmodule

// File: rtl/ocal_chan.sv
module ocal_chan #(
   parameter int SAMPLE_W = 16,
   parameter int CAL_LOG2 = 10,
   parameter bit SAT_EN   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pwr_dn,
   input  logic                       start_req,
   input  logic                       smp_stb,
   input  logic signed [SAMPLE_W-1:0] smp,
   output logic                       busy,
   output logic signed [SAMPLE_W-1:0] ofs,
   output logic signed [SAMPLE_W-1:0] cor
);
   localparam int DIFF_W = SAMPLE_W + 1;
   localparam logic signed [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic clr_acc;
   logic last_smp;
   logic signed [DIFF_W-1:0] diff;

   ocal_ctrl #(.CAL_LOG2(CAL_LOG2)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_dn   (pwr_dn),
      .start_req(start_req),
      .smp_stb  (smp_stb),
      .busy     (busy),
      .clr_acc  (clr_acc),
      .last_smp (last_smp)
   );

   ocal_accum #(.SAMPLE_W(SAMPLE_W), .CAL_LOG2(CAL_LOG2)) accum_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_dn  (pwr_dn),
      .clr_acc (clr_acc),
      .acc_en  (busy && smp_stb),
      .last_smp(last_smp),
      .smp     (smp),
      .ofs     (ofs)
   );

   assign diff = DIFF_W'(smp) - DIFF_W'(ofs);

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            if (diff[DIFF_W-1] != diff[DIFF_W-2])
               cor = diff[DIFF_W-1] ? NEG_MIN : POS_MAX;
            else
               cor = diff[SAMPLE_W-1:0];
         end
      end else begin : g_wrap
         assign cor = diff[SAMPLE_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq #(
   parameter int NUM_CH   = 2,
   parameter int SAMPLE_W = 16,
   parameter int CAL_LOG2 = 10,
   parameter bit SAT_EN   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pwr_dn,
   input  logic                         ctl_wr,
   input  logic [NUM_CH-1:0]            ctl_wdata,
   output logic [NUM_CH-1:0]            ctl_rdata,
   input  logic                         smp_stb,
   input  logic [NUM_CH*SAMPLE_W-1:0]   adc_smp,
   output logic [NUM_CH-1:0]            in_hiz,
   output logic [NUM_CH-1:0]            out_rst,
   output logic [NUM_CH-1:0]            data_vld,
   output logic [NUM_CH*SAMPLE_W-1:0]   ofs_val,
   output logic [NUM_CH*SAMPLE_W-1:0]   cor_smp
);
   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
         $error("offset_cal_seq: NUM_CH must lie in 1..32");
      end
      if (SAMPLE_W < 2) begin : g_bad_w
         $error("offset_cal_seq: SAMPLE_W must be at least 2");
      end
      if (CAL_LOG2 < 1 || CAL_LOG2 > 20) begin : g_bad_len
         $error("offset_cal_seq: CAL_LOG2 must lie in 1..20");
      end
   endgenerate

   logic [NUM_CH-1:0] busy;

   assign ctl_rdata = busy;
   assign in_hiz    = busy;
   assign out_rst   = busy;
   assign data_vld  = ~busy;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic signed [SAMPLE_W-1:0] ofs_i;
         logic signed [SAMPLE_W-1:0] cor_i;

         ocal_chan #(.SAMPLE_W(SAMPLE_W), .CAL_LOG2(CAL_LOG2), .SAT_EN(SAT_EN)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwr_dn   (pwr_dn),
            .start_req(ctl_wr && ctl_wdata[i]),
            .smp_stb  (smp_stb),
            .smp      (adc_smp[i*SAMPLE_W +: SAMPLE_W]),
            .busy     (busy[i]),
            .ofs      (ofs_i),
            .cor      (cor_i)
         );

         assign ofs_val[i*SAMPLE_W +: SAMPLE_W] = ofs_i;
         assign cor_smp[i*SAMPLE_W +: SAMPLE_W] = cor_i;

         // R4: analog controls follow the channel's busy bit
         assert_ctl_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_rdata[i] |-> in_hiz[i] && out_rst[i] && !data_vld[i]);

         // R9: power-down leaves the channel idle
         assert_pd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_dn |=> !ctl_rdata[i] && data_vld[i]);
      end
   endgenerate
endmodule

// File: tb/offset_cal_seq_tb_top.sv
module offset_cal_seq_tb_top;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b0;
   logic ctl_wr = 1'b0;
   logic [1:0] ctl_wdata = '0;
   logic [1:0] ctl_rdata;
   logic smp_stb = 1'b0;
   logic signed [W-1:0] a0 = '0;
   logic signed [W-1:0] a1 = '0;
   logic [2*W-1:0] adc_smp;
   logic [1:0] in_hiz, out_rst, data_vld;
   logic [2*W-1:0] ofs_val, cor_smp;

   int checks = 0;
   int errors = 0;
   bit alt_ch1 = 1'b0;
   bit tog = 1'b0;

   assign adc_smp = {a1, a0};

   always #10 clk = ~clk;

   offset_cal_seq dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .smp_stb(smp_stb), .adc_smp(adc_smp),
      .in_hiz(in_hiz), .out_rst(out_rst), .data_vld(data_vld),
      .ofs_val(ofs_val), .cor_smp(cor_smp)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sx(input logic [W-1:0] v);
      return longint'(signed'(v));
   endfunction

   task automatic wr_ctl(input logic [1:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic strobes(input int n);
      for (int k = 0; k < n; k++) begin
         if (alt_ch1) begin
            a1 = tog ? -16'sd37 : -16'sd38;
            tog = ~tog;
         end
         @(negedge clk); smp_stb = 1'b1;
         @(negedge clk); smp_stb = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9 reset busy", ctl_rdata, 0);
      chk("R4 reset hiz", in_hiz, 0);
      chk("R4 reset vld", data_vld, 3);
      chk("R9 reset ofs", ofs_val, 0);
   endtask

   task automatic t_single;
      a0 = 16'sd100; a1 = 16'sd5;
      wr_ctl(2'b01);
      chk("R1 start ch0", ctl_rdata, 1);
      chk("R4 hiz ch0", in_hiz, 1);
      chk("R4 orst ch0", out_rst, 1);
      chk("R4 vld ch0", data_vld, 2);
      repeat (20) @(negedge clk);
      chk("R2 idle cycles hold", ctl_rdata, 1);
      strobes(1023);
      chk("R2 busy after 1023", ctl_rdata, 1);
      strobes(1);
      chk("R3 self clear", ctl_rdata, 0);
      chk("R4 vld after", data_vld, 3);
      chk("R5 ofs ch0", sx(ofs_val[W-1:0]), 100);
      chk("R8 ch1 untouched", sx(ofs_val[2*W-1:W]), 0);
      a0 = 16'sd130;
      #1 chk("R6 cor ch0", sx(cor_smp[W-1:0]), 30);
   endtask

   task automatic t_concurrent;
      a0 = 16'sd200; alt_ch1 = 1'b1;
      wr_ctl(2'b01);
      strobes(10);
      wr_ctl(2'b11);
      chk("R8 both busy", ctl_rdata, 3);
      strobes(1013);
      chk("R7 ch0 not restarted still busy", ctl_rdata, 3);
      strobes(1);
      chk("R7 ch0 ends on own count", ctl_rdata, 2);
      chk("R5 ofs ch0 200", sx(ofs_val[W-1:0]), 200);
      strobes(9);
      chk("R8 ch1 still busy", ctl_rdata, 2);
      strobes(1);
      chk("R8 ch1 ends", ctl_rdata, 0);
      chk("R5 floor negative avg", sx(ofs_val[2*W-1:W]), -38);
      alt_ch1 = 1'b0;
   endtask

   task automatic t_write_zero;
      wr_ctl(2'b00);
      chk("R7 zero idle", ctl_rdata, 0);
      wr_ctl(2'b10);
      strobes(5);
      wr_ctl(2'b00);
      chk("R7 zero keeps run", ctl_rdata, 2);
      strobes(1019);
      chk("R7 run length kept", ctl_rdata, 0);
   endtask

   task automatic t_saturate;
      a1 = -16'sd32768;
      wr_ctl(2'b10);
      strobes(1024);
      chk("R5 ofs min", sx(ofs_val[2*W-1:W]), -32768);
      a1 = 16'sd32767;
      #1 chk("R6 sat high", sx(cor_smp[2*W-1:W]), 32767);
      a1 = -16'sd32768;
      #1 chk("R6 zero", sx(cor_smp[2*W-1:W]), 0);
      a0 = -16'sd32768;
      #1 chk("R6 sat low", sx(cor_smp[W-1:0]), -32768);
   endtask

   task automatic t_powerdown;
      a0 = 16'sd7;
      wr_ctl(2'b01);
      strobes(100);
      @(negedge clk); pwr_dn = 1'b1;
      @(negedge clk); pwr_dn = 1'b0;
      chk("R9 pd busy", ctl_rdata, 0);
      chk("R9 pd ofs", ofs_val, 0);
      chk("R9 pd vld", data_vld, 3);
      strobes(1100);
      chk("R9 no auto cal", ctl_rdata, 0);
      chk("R9 ofs stays 0", ofs_val, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_concurrent();
      t_write_zero();
      t_saturate();
      t_powerdown();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule